// File: doc/BRIEF.md
# CAN Channel Mode Transition Controller

This block sequences the operating mode of one CAN channel. Software writes a 2-bit mode command through a write strobe. The protocol engine reports its frame and bus-off activity on plain status pins. From these the block decides when a commanded mode takes effect and holds the resulting channel mode in a register. Whenever the channel is not communicating, it asserts a stop signal to the protocol engine.

A reset command acts on the next clock edge and never waits. A halt command is remembered as pending until it is safe to act on. Safe means three things: the frame in flight has ended, the bus is not stuck dominant, and the selected bus-off policy allows it. Two of the four bus-off policies also put the channel into halt with no command at all. There is no data stream, so every pin is a plain control or status signal with no back-pressure.

Top module: `can_chmode_ctrl`

## Requirements
- R1: When rst_n is low at a rising clock edge, cur_mode becomes 2'b01 (reset) and comm_stop becomes 1. Any pending halt and the bus-off state are cleared.
- R2: A write (req_we=1) of 2'b01 sets cur_mode to 2'b01 after that edge in every situation: reception or transmission busy, bus-off, or dominant lock. The write also clears the pending halt and the bus-off state.
- R3: A write of 2'b10 while communicating (cur_mode 2'b00) with no frame busy, no bus-off and no dominant lock sets cur_mode to 2'b10 after that edge. comm_stop is 1 in every cycle where cur_mode is not 2'b00.
- R4: A halt write made while rx_busy or tx_busy is 1 stays pending. It takes effect after the edge where frame_done is 1, or after the first edge where neither busy input is 1.
- R5: Bus-off starts on a busoff_enter pulse while communicating and ends on a busoff_recovered pulse. Under policies 2'b00, 2'b01 and 2'b10, a halt write made during bus-off waits for the recovery pulse and takes effect after that edge.
- R6: Under policy 2'b01, a busoff_enter pulse while communicating sets cur_mode to 2'b10 after that edge, with no write needed.
- R7: Under policy 2'b10, a busoff_recovered pulse during bus-off sets cur_mode to 2'b10 after that edge, with no write needed.
- R8: Under policy 2'b11, a halt write during bus-off takes effect after that edge, before recovery.
- R9: While dom_lock is 1, a halt write never takes effect and stays pending. When dom_lock returns to 0, the pending halt is taken at the next edge, unless a reset or communicate write has cleared it.
- R10: A write of 2'b00 sets cur_mode to 2'b00 after that edge, from halt or from reset, and cancels any pending halt. cur_mode only ever shows 2'b00, 2'b01 or 2'b10.
- R11: A write of 2'b11 is ignored, and so is any value presented while req_we is 0. Neither one changes the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_we | input | 1 | Write strobe for req_mode |
| req_mode | input | 2 | Commanded mode: 00 communicate, 01 reset, 10 halt, 11 ignored |
| bo_policy | input | 2 | Bus-off halt policy, 00 to 11 |
| rx_busy | input | 1 | Reception in progress |
| tx_busy | input | 1 | Transmission in progress |
| frame_done | input | 1 | Current frame completes this cycle |
| busoff_enter | input | 1 | Bus-off entry condition met this cycle |
| busoff_recovered | input | 1 | Bus-off recovery completes this cycle |
| dom_lock | input | 1 | Bus is locked at dominant |
| cur_mode | output | 2 | Current mode: 00 communicate, 01 reset, 10 halt |
| comm_stop | output | 1 | Protocol engine must stop communicating |

## Verification
The assertions watch every cycle for a small set of properties:
- a reset write always lands on the next edge;
- a busy frame without a completion pulse never lets halt through;
- dominant lock holds the channel out of halt while in reset;
- policy 01 halts at bus-off entry;
- policy 00 keeps the channel communicating until recovery;
- the stop output agrees with the mode.

Other behaviours need history, so only the bench scenarios show them. These are the pending halt that survives several cycles and lands later, the pending halt that a reset write cancels, recovery-triggered halt under policy 10, and early halt under policy 11. They also include the bus-off state being cleared by reset and the ignored 2'b11 writes.

// File: rtl/can_chmode_pkg.sv
package can_chmode_pkg;
  localparam int MODE_W = 2;
  localparam int POL_W  = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_COMM  = 2'b00,
    MODE_RESET = 2'b01,
    MODE_HALT  = 2'b10
  } chmode_e;

  localparam logic [POL_W-1:0] POL_WAIT_REQ  = 2'b00;
  localparam logic [POL_W-1:0] POL_AT_ENTRY  = 2'b01;
  localparam logic [POL_W-1:0] POL_AT_RECOV  = 2'b10;
  localparam logic [POL_W-1:0] POL_IMMEDIATE = 2'b11;
endpackage

// File: rtl/chmode_req_dec.sv
module chmode_req_dec
  import can_chmode_pkg::*;
(
  input  logic              req_we,
  input  logic [MODE_W-1:0] req_mode,
  output logic              do_reset,
  output logic              do_comm,
  output logic              do_halt
);
  always_comb begin
    do_reset = 1'b0;
    do_comm  = 1'b0;
    do_halt  = 1'b0;
    if (req_we) begin
      case (req_mode)
        2'b00:   do_comm  = 1'b1;
        2'b01:   do_reset = 1'b1;
        2'b10:   do_halt  = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/chmode_busoff_trk.sv
module chmode_busoff_trk
  import can_chmode_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_comm,
  input  logic             clear,
  input  logic [POL_W-1:0] bo_policy,
  input  logic             busoff_enter,
  input  logic             busoff_recovered,
  output logic             bo_active,
  output logic             auto_halt,
  output logic             bo_permit
);
  logic bo_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      bo_q <= 1'b0;
    end else if (busoff_recovered) begin
      bo_q <= 1'b0;
    end else if (in_comm && busoff_enter) begin
      bo_q <= 1'b1;
    end
  end

  always_comb begin
    auto_halt = 1'b0;
    if (in_comm) begin
      if (bo_policy == POL_AT_ENTRY && busoff_enter) auto_halt = 1'b1;
      if (bo_policy == POL_AT_RECOV && bo_q && busoff_recovered) auto_halt = 1'b1;
    end
  end

  assign bo_permit = !bo_q || (bo_policy == POL_IMMEDIATE) || busoff_recovered;
  assign bo_active = bo_q;
endmodule

// File: rtl/chmode_halt_arb.sv
module chmode_halt_arb
  import can_chmode_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  chmode_e mode_q,
  input  logic    do_halt,
  input  logic    do_reset,
  input  logic    do_comm,
  input  logic    auto_halt,
  input  logic    rx_busy,
  input  logic    tx_busy,
  input  logic    frame_done,
  input  logic    dom_lock,
  input  logic    bo_permit,
  output logic    take_halt
);
  logic pend_q;
  logic want;
  logic in_comm;
  logic frame_ok;
  logic bo_ok;
  logic clear_pend;

  assign in_comm  = (mode_q == MODE_COMM);
  assign want     = pend_q || do_halt;
  assign frame_ok = !in_comm || !(rx_busy || tx_busy) || frame_done;
  assign bo_ok    = !in_comm || bo_permit;

  assign take_halt = want && (mode_q != MODE_HALT) && !dom_lock && frame_ok && bo_ok;

  assign clear_pend = do_reset || do_comm || auto_halt ||
                      (mode_q == MODE_HALT) || take_halt;

  always_ff @(posedge clk) begin
    if (!rst_n || clear_pend) begin
      pend_q <= 1'b0;
    end else begin
      pend_q <= want;
    end
  end
endmodule

// File: rtl/can_chmode_ctrl.sv
module can_chmode_ctrl
  import can_chmode_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_we,
  input  logic [MODE_W-1:0] req_mode,
  input  logic [POL_W-1:0]  bo_policy,
  input  logic              rx_busy,
  input  logic              tx_busy,
  input  logic              frame_done,
  input  logic              busoff_enter,
  input  logic              busoff_recovered,
  input  logic              dom_lock,
  output logic [MODE_W-1:0] cur_mode,
  output logic              comm_stop
);
  chmode_e mode_q;
  chmode_e mode_d;
  logic    stop_q;
  logic    do_reset, do_comm, do_halt;
  logic    bo_active, auto_halt, bo_permit, take_halt;

  chmode_req_dec u_dec (
    .req_we   (req_we),
    .req_mode (req_mode),
    .do_reset (do_reset),
    .do_comm  (do_comm),
    .do_halt  (do_halt)
  );

  chmode_busoff_trk u_bo (
    .clk              (clk),
    .rst_n            (rst_n),
    .in_comm          (mode_q == MODE_COMM),
    .clear            (do_reset),
    .bo_policy        (bo_policy),
    .busoff_enter     (busoff_enter),
    .busoff_recovered (busoff_recovered),
    .bo_active        (bo_active),
    .auto_halt        (auto_halt),
    .bo_permit        (bo_permit)
  );

  chmode_halt_arb u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_q     (mode_q),
    .do_halt    (do_halt),
    .do_reset   (do_reset),
    .do_comm    (do_comm),
    .auto_halt  (auto_halt),
    .rx_busy    (rx_busy),
    .tx_busy    (tx_busy),
    .frame_done (frame_done),
    .dom_lock   (dom_lock),
    .bo_permit  (bo_permit),
    .take_halt  (take_halt)
  );

  // Priority: reset write, then automatic halt, then communicate write, then halt.
  always_comb begin
    mode_d = mode_q;
    if (do_reset)       mode_d = MODE_RESET;
    else if (auto_halt) mode_d = MODE_HALT;
    else if (do_comm)   mode_d = MODE_COMM;
    else if (take_halt) mode_d = MODE_HALT;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= MODE_RESET;
      stop_q <= 1'b1;
    end else begin
      mode_q <= mode_d;
      stop_q <= (mode_d != MODE_COMM);
    end
  end

  assign cur_mode  = mode_q;
  assign comm_stop = stop_q;
endmodule

// File: rtl/can_chmode_sva.sv
module can_chmode_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       req_we,
  input logic [1:0] req_mode,
  input logic [1:0] bo_policy,
  input logic       rx_busy,
  input logic       tx_busy,
  input logic       frame_done,
  input logic       busoff_enter,
  input logic       busoff_recovered,
  input logic       dom_lock,
  input logic [1:0] cur_mode,
  input logic       comm_stop,
  input logic       bo_active
);
  AST_RESET_NEXT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_we && req_mode == 2'b01) |=> (cur_mode == 2'b01 && comm_stop)); // R2

  AST_STOP_TRACKS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    comm_stop == (cur_mode != 2'b00)); // R3

  AST_HALT_WAITS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode == 2'b00 && (rx_busy || tx_busy) && !frame_done &&
     !busoff_enter && !busoff_recovered) |=> (cur_mode != 2'b10)); // R4

  AST_POL00_HOLDS_COMM: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode == 2'b00 && bo_active && bo_policy == 2'b00 && !busoff_recovered)
    |=> (cur_mode != 2'b10)); // R5

  AST_POL01_AUTO_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode == 2'b00 && bo_policy == 2'b01 && busoff_enter &&
     !(req_we && req_mode == 2'b01)) |=> (cur_mode == 2'b10)); // R6

  AST_LOCK_BLOCKS_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode == 2'b01 && dom_lock) |=> (cur_mode != 2'b10)); // R9

  AST_MODE_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode != 2'b11)); // R10
endmodule

bind can_chmode_ctrl can_chmode_sva u_sva (
  .clk              (clk),
  .rst_n            (rst_n),
  .req_we           (req_we),
  .req_mode         (req_mode),
  .bo_policy        (bo_policy),
  .rx_busy          (rx_busy),
  .tx_busy          (tx_busy),
  .frame_done       (frame_done),
  .busoff_enter     (busoff_enter),
  .busoff_recovered (busoff_recovered),
  .dom_lock         (dom_lock),
  .cur_mode         (cur_mode),
  .comm_stop        (comm_stop),
  .bo_active        (bo_active)
);

// File: tb/tb_can_chmode_ctrl.sv
`timescale 1ns/1ps
module tb_can_chmode_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_we = 1'b0;
  logic [1:0] req_mode = 2'b00;
  logic [1:0] bo_policy = 2'b00;
  logic       rx_busy = 1'b0, tx_busy = 1'b0, frame_done = 1'b0;
  logic       busoff_enter = 1'b0, busoff_recovered = 1'b0, dom_lock = 1'b0;
  logic [1:0] cur_mode;
  logic       comm_stop;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string tag = "R1";

  // reference model state
  int m_mode = 1;
  int m_pend = 0;
  int m_bo = 0;

  always #10 clk = ~clk;

  can_chmode_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_we(req_we), .req_mode(req_mode),
    .bo_policy(bo_policy), .rx_busy(rx_busy), .tx_busy(tx_busy),
    .frame_done(frame_done), .busoff_enter(busoff_enter),
    .busoff_recovered(busoff_recovered), .dom_lock(dom_lock),
    .cur_mode(cur_mode), .comm_stop(comm_stop)
  );

  always @(posedge clk) begin
    int nm, np, nb, hreq, allow, busy;
    cycles = cycles + 1;
    nm = m_mode; np = m_pend; nb = m_bo;
    busy = (rx_busy || tx_busy) ? 1 : 0;
    if (!rst_n) begin
      nm = 1; np = 0; nb = 0;
    end else if (req_we && req_mode == 2'd1) begin
      nm = 1; np = 0; nb = 0;
    end else begin
      if (busoff_recovered) nb = 0;
      else if (m_mode == 0 && busoff_enter) nb = 1;
      hreq = (m_pend != 0 || (req_we && req_mode == 2'd2)) ? 1 : 0;
      if (m_mode == 0 && ((bo_policy == 2'd1 && busoff_enter) ||
                          (bo_policy == 2'd2 && m_bo != 0 && busoff_recovered))) begin
        nm = 2; np = 0;
      end else if (req_we && req_mode == 2'd0) begin
        nm = 0; np = 0;
      end else if (m_mode == 2) begin
        np = 0;
      end else if (hreq != 0) begin
        allow = !dom_lock;
        if (m_mode == 0) begin
          if (busy != 0 && !frame_done) allow = 0;
          if (m_bo != 0 && bo_policy != 2'd3 && !busoff_recovered) allow = 0;
        end
        if (allow != 0) begin nm = 2; np = 0; end
        else np = 1;
      end
    end
    m_mode = nm; m_pend = np; m_bo = nb;
  end

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input logic we, input logic [1:0] r);
    req_we = we; req_mode = r;
    @(posedge clk); #1;
    check(cur_mode == m_mode[1:0], "mode vs model", int'(cur_mode), m_mode);
    check(comm_stop == (m_mode != 0), "stop vs model", int'(comm_stop), (m_mode != 0) ? 1 : 0);
    req_we = 1'b0; frame_done = 1'b0; busoff_enter = 1'b0; busoff_recovered = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 2'b00);
  endtask

  task automatic expect_mode(input logic [1:0] exp, input string what);
    check(cur_mode == exp, what, int'(cur_mode), int'(exp));
  endtask

  initial begin
    #3000000;
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    tag = "R1";
    idle(3);
    expect_mode(2'b01, "mode after reset");
    check(comm_stop == 1'b1, "stop after reset", int'(comm_stop), 1);
    rst_n = 1'b1;
    idle(2);
    expect_mode(2'b01, "reset mode held");

    // R10: return to communication
    tag = "R10";
    cyc(1'b1, 2'b00);
    expect_mode(2'b00, "comm from reset");

    // R3: idle halt
    tag = "R3";
    cyc(1'b1, 2'b10);
    expect_mode(2'b10, "idle halt");
    check(comm_stop == 1'b1, "stop in halt", int'(comm_stop), 1);
    tag = "R10";
    cyc(1'b1, 2'b00);
    expect_mode(2'b00, "comm from halt");

    // R4: halt deferred during reception
    tag = "R4";
    rx_busy = 1'b1;
    cyc(1'b1, 2'b10);
    idle(3);
    expect_mode(2'b00, "halt deferred while busy");
    frame_done = 1'b1;
    cyc(1'b0, 2'b00);
    expect_mode(2'b10, "halt after frame done");
    rx_busy = 1'b0;
    cyc(1'b1, 2'b00);

    // R2: reset during transmission, cancels pending halt
    tag = "R2";
    tx_busy = 1'b1;
    cyc(1'b1, 2'b01);
    expect_mode(2'b01, "reset during tx");
    cyc(1'b1, 2'b00);
    cyc(1'b1, 2'b10);
    cyc(1'b1, 2'b01);
    expect_mode(2'b01, "reset over pending halt");
    cyc(1'b1, 2'b00);
    frame_done = 1'b1;
    cyc(1'b0, 2'b00);
    tx_busy = 1'b0;
    idle(2);
    expect_mode(2'b00, "pending halt cancelled");

    // R5: policy 00 waits for recovery
    tag = "R5";
    bo_policy = 2'b00;
    busoff_enter = 1'b1;
    cyc(1'b0, 2'b00);
    cyc(1'b1, 2'b10);
    idle(4);
    expect_mode(2'b00, "pol00 halt waits");
    busoff_recovered = 1'b1;
    cyc(1'b0, 2'b00);
    expect_mode(2'b10, "pol00 halt after recovery");
    cyc(1'b1, 2'b00);

    // R6: policy 01 auto halt at entry
    tag = "R6";
    bo_policy = 2'b01;
    busoff_enter = 1'b1;
    cyc(1'b0, 2'b00);
    expect_mode(2'b10, "pol01 auto halt");
    busoff_recovered = 1'b1;
    cyc(1'b0, 2'b00);
    cyc(1'b1, 2'b00);

    // R7: policy 10 auto halt at recovery
    tag = "R7";
    bo_policy = 2'b10;
    busoff_enter = 1'b1;
    cyc(1'b0, 2'b00);
    idle(3);
    expect_mode(2'b00, "pol10 still comm in busoff");
    busoff_recovered = 1'b1;
    cyc(1'b0, 2'b00);
    expect_mode(2'b10, "pol10 auto halt after recovery");
    cyc(1'b1, 2'b00);

    // R8: policy 11 immediate halt in bus-off
    tag = "R8";
    bo_policy = 2'b11;
    busoff_enter = 1'b1;
    cyc(1'b0, 2'b00);
    cyc(1'b1, 2'b10);
    expect_mode(2'b10, "pol11 halt before recovery");
    busoff_recovered = 1'b1;
    cyc(1'b0, 2'b00);
    cyc(1'b1, 2'b00);

    // R2: reset during bus-off clears bus-off state
    tag = "R2";
    bo_policy = 2'b00;
    busoff_enter = 1'b1;
    cyc(1'b0, 2'b00);
    cyc(1'b1, 2'b01);
    expect_mode(2'b01, "reset during busoff");
    cyc(1'b1, 2'b00);
    cyc(1'b1, 2'b10);
    expect_mode(2'b10, "busoff cleared by reset");
    cyc(1'b1, 2'b00);

    // R9: dominant lock blocks halt
    tag = "R9";
    dom_lock = 1'b1;
    cyc(1'b1, 2'b10);
    idle(4);
    expect_mode(2'b00, "halt blocked by lock");
    dom_lock = 1'b0;
    cyc(1'b0, 2'b00);
    expect_mode(2'b10, "pending halt after lock clears");
    cyc(1'b1, 2'b00);
    dom_lock = 1'b1;
    cyc(1'b1, 2'b10);
    cyc(1'b1, 2'b01);
    expect_mode(2'b01, "reset escapes lock");
    cyc(1'b1, 2'b10);
    idle(2);
    expect_mode(2'b01, "halt blocked in reset");
    dom_lock = 1'b0;
    cyc(1'b0, 2'b00);
    expect_mode(2'b10, "halt from reset after lock");
    cyc(1'b1, 2'b00);

    // R11: ignored writes
    tag = "R11";
    cyc(1'b1, 2'b11);
    expect_mode(2'b00, "11 ignored in comm");
    cyc(1'b0, 2'b01);
    expect_mode(2'b00, "no strobe ignored");
    cyc(1'b1, 2'b10);
    cyc(1'b1, 2'b11);
    expect_mode(2'b10, "11 ignored in halt");
    cyc(1'b0, 2'b00);
    expect_mode(2'b10, "no strobe ignored in halt");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule